// File: doc/BRIEF.md
# 32-bit Multi-Function ALU

This block is a purely combinational integer ALU for a 32-bit datapath. A 4-bit operation select chooses one of sixteen codes that cover addition, subtraction, four bitwise functions, three barrel shifts and four single-bit tests. Its inputs are two operands and a 5-bit shift count. It drives a 32-bit result and a signed-overflow flag. The block holds no state, so the result follows the inputs within the same cycle.

Addition and subtraction share one adder. Subtraction feeds the inverted second operand and a carry-in of one. The shifts always act on the second operand and never on the first. Every test returns its answer in bit 0, with the upper bits cleared. The select ignores the lowest bit for the left shift, add and subtract codes.

Top module: `alu32`

## Requirements
- R1: Codes 0010 and 0011 drive `result` with `opnd_a + opnd_b` modulo 2^32.
- R2: Codes 0110 and 0111 drive `result` with `opnd_a - opnd_b` modulo 2^32.
- R3: `ovf` is 1 under two conditions. For an add, it is 1 when both operands have the same sign bit and the result's bit 31 differs from it. For a subtract, it is 1 when the operands' sign bits differ and the result's bit 31 differs from `opnd_a[31]`. It is 0 otherwise.
- R4: `ovf` is 0 for every code other than 0010, 0011, 0110 and 0111.
- R5: The bitwise codes are: 0100 gives AND, 0101 gives OR, 1010 gives XOR and 1011 gives NOR, all of `opnd_a` with `opnd_b`.
- R6: Codes 0000 and 0001 shift `opnd_b` left by `shamt` and fill with zeros.
- R7: Code 1100 shifts `opnd_b` right by `shamt` and fills with zeros. Code 1101 shifts it right and fills with copies of `opnd_b[31]`.
- R8: For the three shift operations, `result` does not depend on `opnd_a`.
- R9: A `shamt` of 0 passes `opnd_b` to `result` unchanged for all three shift operations.
- R10: Code 1000 gives 1 when `opnd_a != opnd_b`, and code 1001 gives 1 when they are equal. Otherwise the result is 0, and bits 31:1 are always 0.
- R11: Code 1110 gives 1 when signed `opnd_a <= 0`, and code 1111 gives 1 when signed `opnd_a > 0`. Otherwise the result is 0, and bits 31:1 are always 0.
- R12: Outputs are a function of the present inputs alone and settle within the cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, also the shift source |
| shamt | input | 5 | Shift count, 0 to 31 |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow for add and subtract |

## Verification
Every result and the overflow flag are due in zero cycles. The outputs depend only on the inputs present at that moment. The bench applies each input set just after a rising edge and reads `result` and `ovf` at the following falling edge, half a period later, so the logic has settled before any comparison. No check waits across a clock edge, so a value from an earlier input set can never pass as the current one.

// File: rtl/alu32.sv
module alu32 #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic is_add, is_sub, is_arith;
  logic is_shl, is_shr, is_sra, is_shift;
  assign is_add   = (op_sel[3:1] == 3'b001);
  assign is_sub   = (op_sel[3:1] == 3'b011);
  assign is_arith = is_add | is_sub;
  assign is_shl   = (op_sel[3:1] == 3'b000);
  assign is_shr   = (op_sel == 4'b1100);
  assign is_sra   = (op_sel == 4'b1101);
  assign is_shift = is_shl | is_shr | is_sra;

  logic [WIDTH-1:0] addend, sum;
  logic             carry_out;
  assign addend = is_sub ? ~opnd_b : opnd_b;
  assign {carry_out, sum} = {1'b0, opnd_a} + {1'b0, addend} + {{WIDTH{1'b0}}, is_sub};

  logic sum_ovf;
  assign sum_ovf = (opnd_a[MSB] == addend[MSB]) && (sum[MSB] != opnd_a[MSB]);

  logic [WIDTH-1:0] b_rev, sh_rev;
  logic [WIDTH-1:0] stage [SHW+1];
  logic             fill;
  assign fill = is_sra & opnd_b[MSB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign b_rev[i]  = opnd_b[MSB-i];
    assign sh_rev[i] = stage[SHW][MSB-i];
  end

  assign stage[0] = is_shl ? b_rev : opnd_b;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt[k] ? {{STEP{fill}}, stage[k][MSB:STEP]} : stage[k];
  end

  logic [WIDTH-1:0] shifted;
  assign shifted = is_shl ? sh_rev : stage[SHW];

  logic a_eq_b, a_le_0;
  assign a_eq_b = (opnd_a == opnd_b);
  assign a_le_0 = opnd_a[MSB] | ~|opnd_a;

  always_comb begin
    result = '0;
    unique case (op_sel)
      4'b0000, 4'b0001: result = shifted;
      4'b0010, 4'b0011,
      4'b0110, 4'b0111: result = sum;
      4'b0100: result = opnd_a & opnd_b;
      4'b0101: result = opnd_a | opnd_b;
      4'b1000: result[0] = ~a_eq_b;
      4'b1001: result[0] = a_eq_b;
      4'b1010: result = opnd_a ^ opnd_b;
      4'b1011: result = ~(opnd_a | opnd_b);
      4'b1100, 4'b1101: result = shifted;
      4'b1110: result[0] = a_le_0;
      4'b1111: result[0] = ~a_le_0;
      default: result = '0;
    endcase
  end

  assign ovf = is_arith & sum_ovf;

  always_comb begin
    // R4
    v_quiet_chk: assert (is_arith || !ovf);
    // R3
    ovf_sign_chk: assert (!ovf || (result[MSB] != opnd_a[MSB]));
    // R9
    shift_zero_chk: assert (!(is_shift && shamt == '0) || result == opnd_b);
    // R10
    cmp_upper_chk: assert (!(op_sel[3:1] == 3'b100 || op_sel[3:1] == 3'b111) || result[MSB:1] == '0);
    // R7
    sra_sign_chk: assert (!(is_sra && opnd_b[MSB]) || result[MSB]);
    // R6
    shl_zero_chk: assert (!(is_shl && shamt != '0) || !result[0]);
  end
endmodule

// File: tb/alu32_tb_top.sv
module alu32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu32 dut_i (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
               .shamt(shamt), .result(result), .ovf(ovf));

  function automatic logic [32:0] model(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic [4:0] s);
    logic [31:0] c = '0;
    logic v = 1'b0;
    case (o)
      4'b0000, 4'b0001: c = b << s;
      4'b0010, 4'b0011: begin c = a + b; v = (a[31] == b[31]) && (c[31] != a[31]); end
      4'b0110, 4'b0111: begin c = a - b; v = (a[31] != b[31]) && (c[31] != a[31]); end
      4'b0100: c = a & b;
      4'b0101: c = a | b;
      4'b1010: c = a ^ b;
      4'b1011: c = ~(a | b);
      4'b1100: c = b >> s;
      4'b1101: c = $unsigned($signed(b) >>> s);
      4'b1000: c = {31'b0, a != b};
      4'b1001: c = {31'b0, a == b};
      4'b1110: c = {31'b0, $signed(a) <= 0};
      default: c = {31'b0, $signed(a) > 0};
    endcase
    return {v, c};
  endfunction

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'b0000, 4'b0001: return "R6";
      4'b0010, 4'b0011: return "R1/R3";
      4'b0110, 4'b0111: return "R2/R3";
      4'b0100, 4'b0101, 4'b1010, 4'b1011: return "R5/R4";
      4'b1100, 4'b1101: return "R7";
      4'b1000, 4'b1001: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [32:0] exp);
    checks++;
    if ({ovf, result} !== exp) begin
      failures++;
      $display("FAIL %s op=%b a=%h b=%h sa=%0d actual v=%b c=%h expected v=%b c=%h",
               req, op_sel, opnd_a, opnd_b, shamt, ovf, result, exp[32], exp[31:0]);
    end
  endtask

  // R12: drive after the rising edge, compare at the falling edge of the same cycle
  task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic [4:0] s);
    @(posedge clk);
    op_sel = o; opnd_a = a; opnd_b = b; shamt = s;
    @(negedge clk);
    check(req_of(o), model(o, a, b, s));
  endtask

  initial begin
    logic [31:0] corners [5];
    logic [31:0] first;
    void'($urandom(32'd20240611));
    corners[0] = 32'h0; corners[1] = 32'h1; corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF; corners[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle", 33'h0);

    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          apply(o[3:0], corners[i], corners[j], 5'd0);
          apply(o[3:0], corners[i], corners[j], 5'd31);
        end

    // R9: a zero count passes the operand through
    foreach (corners[i]) begin
      apply(4'b0001, 32'h1234_5678, corners[i], 5'd0);
      check("R9 shl", {1'b0, corners[i]});
      apply(4'b1100, 32'h0, corners[i], 5'd0);
      check("R9 shr", {1'b0, corners[i]});
      apply(4'b1101, 32'hFFFF_FFFF, corners[i], 5'd0);
      check("R9 sra", {1'b0, corners[i]});
    end

    // R8: changing the first operand leaves shift results unchanged
    for (int n = 0; n < 30; n++) begin
      logic [31:0] b = $urandom;
      logic [4:0]  s = 5'($urandom);
      logic [3:0]  o = (n % 3 == 0) ? 4'b0000 : (n % 3 == 1) ? 4'b1100 : 4'b1101;
      apply(o, $urandom, b, s);
      first = result;
      apply(o, $urandom, b, s);
      check("R8", {1'b0, first});
    end

    // R3: boundary overflow cases
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1, 5'd0);
    check("R3 add pos", {1'b1, 32'h8000_0000});
    apply(4'b0111, 32'h8000_0000, 32'h1, 5'd0);
    check("R3 sub neg", {1'b1, 32'h7FFF_FFFF});
    apply(4'b0110, 32'h0, 32'h8000_0000, 5'd0);
    check("R3 sub min", {1'b1, 32'h8000_0000});

    for (int n = 0; n < 3000; n++)
      apply(4'($urandom), $urandom, (n % 7 == 0) ? opnd_a : $urandom, 5'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule